// File: doc/BRIEF.md
# Serial Configuration EEPROM Word Reader

This block fetches a single 16-bit word from a three-wire serial EEPROM. The host presents a 6-bit word address together with a one-cycle `start` strobe. The block then runs one complete read transaction. It asserts chip select, clocks out the read opcode `110` and the address most significant bit first, and clocks in sixteen data bits. It returns the assembled word on `rdata` with a one-cycle `done` strobe.

Every serial clock phase lasts exactly `HALF_CYC` system clocks. The default of 500 gives a 5 µs half period at 100 MHz, and any other system clock rate is met by scaling the parameter. A single shift register serves both directions. The command is loaded left-aligned and shifted out of the top bit, and the returned data shifts in at the bottom. The same register drives `rdata`, so `rdata` holds meaningful data only from `done` until the next accepted `start`.

The controller is a Moore machine whose outputs are all registered. Its states are:

- `ST_IDLE` waits for `start`.
- `ST_ARM` holds chip select low for one half period.
- `ST_SELECT` raises chip select with the clock low.
- `ST_CMD_LO` and `ST_CMD_HI` form one command clock pulse.
- `ST_RD_LO` and `ST_RD_HI` form one readback pulse.
- `ST_TAIL` holds the clock low with chip select still high.
- `ST_DESEL` drops chip select.

The transitions are:

- `ST_IDLE` goes to `ST_ARM` on `start`.
- Each of `ST_ARM`, `ST_SELECT`, `ST_CMD_LO`, `ST_RD_LO`, `ST_TAIL` and `ST_DESEL` advances to the next state at the end of its half period.
- `ST_CMD_HI` returns to `ST_CMD_LO` while command bits remain, and otherwise goes to `ST_RD_LO`.
- `ST_RD_HI` returns to `ST_RD_LO` while data bits remain, and otherwise goes to `ST_TAIL`.
- `ST_DESEL` goes to `ST_IDLE` and raises `done`.

Top module: `eeprom_word_reader`

## Requirements
- R1: While no transfer is in progress (including right after reset), `prom_cs`, `prom_sclk`, `prom_mosi`, `busy` and `done` are 0.
- R2: A `start` seen while idle makes `busy` 1 in the next cycle. `prom_cs` then stays 0 for exactly `HALF_CYC` cycles before it rises.
- R3: The first three serial clock pulses carry the opcode bits 1, 1, 0 in that order on `prom_mosi`, which is stable while `prom_sclk` is high.
- R4: Pulses 4 to 9 carry the 6-bit address, most significant bit first.
- R5: Each transfer has exactly 25 rising edges of `prom_sclk` while `prom_cs` is high: 9 command pulses and 16 readback pulses.
- R6: Readback bits are sampled from `prom_miso` at the end of each clock-high phase. The first bit lands in `rdata[15]` and the last in `rdata[0]`.
- R7: Every `prom_sclk` high phase lasts exactly `HALF_CYC` cycles, and no low phase is shorter than `HALF_CYC` cycles.
- R8: `prom_mosi` is 0 from the fall after the ninth pulse until chip select drops.
- R9: `prom_sclk` is high only while `prom_cs` is high. After the last readback pulse the clock returns low for a half period before `prom_cs` falls.
- R10: `done` is a single-cycle pulse in the cycle `busy` falls. `rdata` then holds the word until the next accepted `start`.
- R11: `start` while `busy` is 1 is ignored. The running transfer completes with its original address and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to read a word |
| addr | input | ADDR_W | Word address, sampled with `start` |
| busy | output | 1 | High from the cycle after `start` until `done` |
| done | output | 1 | One-cycle strobe, word valid on `rdata` |
| rdata | output | DATA_W | Word read from the EEPROM |
| prom_cs | output | 1 | EEPROM chip select, active high |
| prom_sclk | output | 1 | EEPROM serial clock |
| prom_mosi | output | 1 | Serial data toward the EEPROM |
| prom_miso | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the block with `HALF_CYC` = 3 and the default 6-bit address and 16-bit word. The short half period keeps each transfer near 160 cycles, so boundary addresses, all-zero, all-one and alternating words, and a start request in mid-transfer all fit in a brief run. A half period of three cycles still leaves the phase counter a middle value between wrap points. This exposes an off-by-one in the width of a clock phase or of the chip-select lead-in as a wrong cycle count.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

    localparam int OPC_W = 3;
    localparam logic [OPC_W-1:0] READ_OPCODE = 3'b110;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARM,
        ST_SELECT,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_RD_LO,
        ST_RD_HI,
        ST_TAIL,
        ST_DESEL
    } eerd_state_e;

endpackage

// File: rtl/eerd_halfper.sv
// Half-period timer: runs while a transfer is active, strobes tick in the
// last cycle of each half period and wraps, so every state boundary lines up.
module eerd_halfper #(
    parameter int HALF_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/eerd_shreg.sv
// Left-shifting register with parallel load: the top bit leaves toward the
// EEPROM, new bits enter at the bottom.
module eerd_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end

endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
    import eerd_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int HALF_CYC = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              prom_cs,
    output logic              prom_sclk,
    output logic              prom_mosi,
    input  logic              prom_miso
);

    localparam int CMD_W = OPC_W + ADDR_W;
    localparam int BCW   = $clog2(DATA_W);
    localparam logic [BCW-1:0] CMD_LAST  = BCW'(CMD_W - 1);
    localparam logic [BCW-1:0] DATA_LAST = BCW'(DATA_W - 1);
    localparam logic [DATA_W-1:0] CMD_ALIGN_SHIFT = DATA_W'(DATA_W - CMD_W);

    generate
        if (DATA_W < CMD_W) begin : g_width_check
            $error("eeprom_word_reader: DATA_W must be at least OPC_W + ADDR_W");
        end
    endgenerate

    eerd_state_e state_q, state_nx;
    logic              tick;
    logic [BCW-1:0]    bit_q;
    logic              bit_zero;
    logic              accept;
    logic              sr_shift;
    logic              sr_sin;
    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] sr_load;
    logic              mosi_nx;

    assign accept   = (state_q == ST_IDLE) && start;
    assign bit_zero = (bit_q == '0);

    // Half-period timing.
    eerd_halfper #(
        .HALF_CYC (HALF_CYC)
    ) u_halfper (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .tick  (tick)
    );

    // Shared command / readback register: command left-aligned at load,
    // leaves through the top bit while data fills from the bottom.
    assign sr_load  = DATA_W'({READ_OPCODE, addr}) << CMD_ALIGN_SHIFT;
    assign sr_shift = tick && ((state_q == ST_CMD_HI) || (state_q == ST_RD_HI));
    assign sr_sin   = (state_q == ST_RD_HI) ? prom_miso : 1'b0;

    eerd_shreg #(
        .W (DATA_W)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (sr_load),
        .shift    (sr_shift),
        .sin      (sr_sin),
        .q        (sr_q)
    );

    // Bit counter for both phases.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (accept) begin
            bit_q <= CMD_LAST;
        end else if (tick && (state_q == ST_CMD_HI)) begin
            bit_q <= bit_zero ? DATA_LAST : bit_q - 1'b1;
        end else if (tick && (state_q == ST_RD_HI) && !bit_zero) begin
            bit_q <= bit_q - 1'b1;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_nx = ST_ARM;
            ST_ARM:    if (tick)  state_nx = ST_SELECT;
            ST_SELECT: if (tick)  state_nx = ST_CMD_LO;
            ST_CMD_LO: if (tick)  state_nx = ST_CMD_HI;
            ST_CMD_HI: if (tick)  state_nx = bit_zero ? ST_RD_LO : ST_CMD_LO;
            ST_RD_LO:  if (tick)  state_nx = ST_RD_HI;
            ST_RD_HI:  if (tick)  state_nx = bit_zero ? ST_TAIL : ST_RD_LO;
            ST_TAIL:   if (tick)  state_nx = ST_DESEL;
            ST_DESEL:  if (tick)  state_nx = ST_IDLE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Registered outputs, decoded from the state being entered.
    assign mosi_nx = sr_shift ? sr_q[DATA_W-2] : sr_q[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            prom_cs   <= 1'b0;
            prom_sclk <= 1'b0;
            prom_mosi <= 1'b0;
        end else begin
            busy      <= (state_nx != ST_IDLE);
            done      <= (state_q == ST_DESEL) && tick;
            prom_cs   <= (state_nx inside {ST_SELECT, ST_CMD_LO, ST_CMD_HI,
                                           ST_RD_LO, ST_RD_HI, ST_TAIL});
            prom_sclk <= (state_nx inside {ST_CMD_HI, ST_RD_HI});
            prom_mosi <= (state_nx inside {ST_CMD_LO, ST_CMD_HI}) ? mosi_nx : 1'b0;
        end
    end

    assign rdata = sr_q;

endmodule

// File: rtl/eerd_checker.sv
module eerd_checker #(
    parameter int HALF_CYC = 500,
    parameter int CMD_BITS = 9,
    parameter int PULSES   = 25
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic cs,
    input logic sclk,
    input logic mosi
);

    localparam int RW = $clog2(HALF_CYC + 1);
    localparam int PW = $clog2(PULSES + 1);
    localparam logic [RW-1:0] HALF = RW'(HALF_CYC);
    localparam logic [PW-1:0] NCMD = PW'(CMD_BITS);
    localparam logic [PW-1:0] NALL = PW'(PULSES);

    logic          sk_d;
    logic          cs_d;
    logic [RW-1:0] run;
    logic [PW-1:0] pulses;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_d   <= 1'b0;
            cs_d   <= 1'b0;
            run    <= HALF;
            pulses <= '0;
        end else begin
            sk_d <= sclk;
            cs_d <= cs;
            if (sclk != sk_d) begin
                run <= RW'(1);
            end else if (run < HALF) begin
                run <= run + 1'b1;
            end
            if (!cs) begin
                pulses <= '0;
            end else if (sclk && !sk_d) begin
                pulses <= pulses + 1'b1;
            end
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cs && !sclk && !mosi));

    assert_select_after_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !cs_d) |-> $past(busy));

    assert_mosi_stable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && sk_d) |-> $stable(mosi));

    assert_pulse_total_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && cs_d) |-> (pulses == NALL));

    assert_phase_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != sk_d) |-> (run >= HALF));

    assert_mosi_low_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && ((pulses > NCMD) || ((pulses == NCMD) && !sclk))) |-> !mosi);

    assert_sclk_inside_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> cs);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cs && $past(busy)));

endmodule

bind eeprom_word_reader eerd_checker #(
    .HALF_CYC (HALF_CYC),
    .CMD_BITS (3 + ADDR_W),
    .PULSES   (3 + ADDR_W + DATA_W)
) i_eerd_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .cs    (prom_cs),
    .sclk  (prom_sclk),
    .mosi  (prom_mosi)
);

// File: tb/test_eeprom_word_reader.sv
`timescale 1ns/1ps
module test_eeprom_word_reader;

    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  addr_in = '0;
    logic        busy, done;
    logic [15:0] rdata;
    logic        prom_cs, prom_sclk, prom_mosi;
    logic        miso = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    eeprom_word_reader #(
        .ADDR_W   (6),
        .DATA_W   (16),
        .HALF_CYC (H)
    ) i_eeprom_word_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .addr      (addr_in),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .prom_cs   (prom_cs),
        .prom_sclk (prom_sclk),
        .prom_mosi (prom_mosi),
        .prom_miso (miso)
    );

    // EEPROM model
    logic [15:0] model_word = '0;
    logic [8:0]  cmd_cap = '0;
    int          pulse_idx = 0;
    int          xfers = 0;
    bit          di_bad = 0;
    bit          cs_sk_bad = 0;

    always @(posedge prom_cs) begin
        pulse_idx = 0;
        cmd_cap   = '0;
        xfers++;
    end

    always @(negedge prom_cs) begin
        if (prom_sclk) cs_sk_bad = 1;
        miso = 1'b0;
    end

    always @(posedge prom_sclk) begin
        #1;
        if (!prom_cs) begin
            cs_sk_bad = 1;
        end else begin
            if (pulse_idx < 9) begin
                cmd_cap = {cmd_cap[7:0], prom_mosi};
            end else begin
                if (prom_mosi) di_bad = 1;
                if (pulse_idx < 25) miso = model_word[24 - pulse_idx];
            end
            pulse_idx++;
        end
    end

    // Clock phase width monitor
    logic mon_prev = 1'b0;
    int   mon_run = 0;
    int   min_hi, max_hi, min_lo;

    always @(negedge clk) begin
        if (prom_sclk !== mon_prev) begin
            if (mon_prev) begin
                if (mon_run < min_hi) min_hi = mon_run;
                if (mon_run > max_hi) max_hi = mon_run;
            end else if (prom_cs) begin
                if (mon_run < min_lo) min_lo = mon_run;
            end
            mon_run = 1;
        end else begin
            mon_run++;
        end
        mon_prev = prom_sclk;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_reset();
        chk("R1 cs after reset", 32'(prom_cs), 0);
        chk("R1 sclk after reset", 32'(prom_sclk), 0);
        chk("R1 mosi after reset", 32'(prom_mosi), 0);
        chk("R1 busy after reset", 32'(busy), 0);
        chk("R1 done after reset", 32'(done), 0);
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic read_word(input logic [5:0] a, input logic [15:0] w, input string name);
        bit seen;
        int x0;
        min_hi = 1000000; max_hi = 0; min_lo = 1000000;
        di_bad = 0; cs_sk_bad = 0;
        model_word = w;
        x0 = xfers;
        @(negedge clk);
        start = 1'b1; addr_in = a;
        @(negedge clk);
        start = 1'b0; addr_in = ~a;
        chk({"R2 busy after start ", name}, 32'(busy), 1);
        chk({"R2 cs low in arm ", name}, 32'(prom_cs), 0);
        repeat (H - 1) @(negedge clk);
        chk({"R2 cs low at end of arm ", name}, 32'(prom_cs), 0);
        @(negedge clk);
        chk({"R2 cs rises after half period ", name}, 32'(prom_cs), 1);
        wait_done(seen);
        chk({"R10 done seen ", name}, 32'(seen), 1);
        chk({"R6 word ", name}, 32'(rdata), 32'(w));
        chk({"R10 busy low at done ", name}, 32'(busy), 0);
        chk({"R9 cs low at done ", name}, 32'(prom_cs), 0);
        chk({"R3 opcode ", name}, 32'(cmd_cap[8:6]), 32'h6);
        chk({"R4 address ", name}, 32'(cmd_cap[5:0]), 32'(a));
        chk({"R5 pulse count ", name}, 32'(pulse_idx), 25);
        chk({"R5 one transfer ", name}, 32'(xfers - x0), 1);
        chk({"R8 mosi low in readback ", name}, 32'(di_bad), 0);
        chk({"R9 sclk low when cs falls ", name}, 32'(cs_sk_bad), 0);
        chk({"R7 min high width ", name}, 32'(min_hi), 32'(H));
        chk({"R7 max high width ", name}, 32'(max_hi), 32'(H));
        chk({"R7 low width at least H ", name}, 32'(min_lo >= H), 1);
        @(negedge clk);
        chk({"R10 done single cycle ", name}, 32'(done), 0);
        repeat (4) @(negedge clk);
        chk({"R10 rdata holds ", name}, 32'(rdata), 32'(w));
        chk({"R1 idle outputs ", name}, 32'({prom_cs, prom_sclk, prom_mosi, busy}), 0);
    endtask

    task automatic start_while_busy();
        bit seen;
        int x0;
        model_word = 16'h3C5A;
        x0 = xfers;
        @(negedge clk);
        start = 1'b1; addr_in = 6'h15;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1; addr_in = 6'h2A;
        @(negedge clk);
        start = 1'b0;
        chk("R11 still busy after second start", 32'(busy), 1);
        wait_done(seen);
        chk("R11 done seen", 32'(seen), 1);
        chk("R11 address kept", 32'(cmd_cap[5:0]), 32'h15);
        chk("R11 word of first request", 32'(rdata), 32'h3C5A);
        repeat (30) @(negedge clk);
        chk("R11 no second transfer", 32'(xfers - x0), 1);
        chk("R11 idle after ignored start", 32'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_reset();
        read_word(6'h00, 16'h0000, "addr0 zero");
        read_word(6'h3F, 16'hFFFF, "addr63 ones");
        read_word(6'h25, 16'hA5C3, "mixed");
        read_word(6'h1A, 16'h8001, "end bits");
        read_word(6'h2B, 16'h5555, "alternating");
        start_while_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule